// File: doc/BRIEF.md
# SPI Command Frame Host Sequencer

This block is the host side of an SPI link to an external controller that keeps registers and a message RAM. A client hands it one request at a time: an operation code, a 12-bit target address and, for array operations, a byte count. The block opens a chip-select window and shifts out a 16-bit header, a 4-bit command followed by the 12-bit address. It then streams data bytes in or out, closes the window and pulses `done`.

Write bytes come in through a valid/ready stream. The sequencer raises `wr_ready` only when the next byte is due on the wire. While `wr_valid` stays low it parks SCK low, so a slow producer stalls the bus and no data is lost. Read bytes leave on `rd_data` with a one-cycle `rd_valid` strobe. That stream has no back-pressure: the consumer must take each byte in the cycle it appears. Word accesses to message RAM must start on a 4-byte boundary. A misaligned word request, or an unknown operation code, is refused and never touches the bus.

Top module: `spi_cmd_seq`

## Requirements
- R1: After reset `spi_cs_n` is high, `spi_sck` low, `busy`, `done`, `err`, `rd_valid` and `wr_ready` are low, and `req_ready` is high.
- R2: A frame starts with a 16-bit header sent MSB first: command in the top 4 bits (4'b0011 read, 4'b0010 write, 4'b0000 reset), then the 12-bit address. Data bytes follow the header, each MSB first. The reset operation sends header 16'h0000 with no data, whatever address is given.
- R3: SPI mode 0. SCK idles low and MOSI changes only while SCK is low. MISO is captured on the rising SCK edge. Each SCK high phase and low phase lasts `half_div` system clocks, and 0 counts as 1.
- R4: Operation codes on `req_op` and their data lengths: 0 reset (0 bytes), 1 read byte (1), 2 write byte (1), 3 read half-word (2), 4 write half-word (2), 5 read word (4), 6 write word (4), 7 read byte array, 8 write byte array, 9 read word array, 10 write word array. The four array codes take `req_len` bytes.
- R5: A word or word-array request (codes 5, 6, 9, 10) with `req_addr[1:0]` not 0, or a code above 10, is accepted and then refused. `done` and `err` pulse together in the cycle after acceptance, and `spi_cs_n` never goes low.
- R6: `req_ready` is high only when idle. `busy` is high from the cycle after acceptance until `done`. `done` is a one-cycle pulse issued after `spi_cs_n` has returned high. `err` stays low for a completed frame.
- R7: `wr_ready` rises only inside a write frame, with SCK low, when the next byte is due. Each handshake moves one byte. While `wr_valid` is low, SCK stays low.
- R8: Between frames `spi_cs_n` stays high for at least one full SCK period (2×`half_div` clocks).
- R9: Each byte received after the header appears on `rd_data` with a single-cycle `rd_valid`, in bus order. Header-phase bits are never returned.
- R10: An array operation sends one header and then exactly `req_len` bytes. With `req_len` = 0 only the header is sent, and a write array then takes no byte from the write stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_div | input | DIV_W | SCK half-period in system clocks (0 acts as 1) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_op | input | 4 | Operation code (see R4) |
| req_addr | input | 12 | Target address placed in the header |
| req_len | input | LEN_W | Byte count for array operations |
| wr_data | input | 8 | Write byte |
| wr_valid | input | 1 | Write byte present |
| wr_ready | output | 1 | Write byte taken this cycle if valid |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Refused request, pulses with `done` |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to slave |
| spi_miso | input | 1 | Serial data from slave |

## Verification
The bound checker watches the line discipline on every cycle. SCK stays low outside a chip-select window and MOSI holds while SCK is high. Chip select holds high for more than one cycle after it rises. `done` comes only with the bus idle, and `err` only with `done`. `wr_ready` appears only inside a window with SCK low, and `rd_valid` only while busy. Header encodings, byte order, per-operation lengths, captured read data, the exact SCK phase lengths for several divider values, the chip-select gap between frames, write stalls and refusals of misaligned or unknown requests can only be shown by the bench's scenarios. These run against a behavioural slave that samples on rising SCK and drives MISO on falling SCK.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam logic [3:0] OP_RESET = 4'd0;
  localparam logic [3:0] OP_RD8   = 4'd1;
  localparam logic [3:0] OP_WR8   = 4'd2;
  localparam logic [3:0] OP_RD16  = 4'd3;
  localparam logic [3:0] OP_WR16  = 4'd4;
  localparam logic [3:0] OP_RD32  = 4'd5;
  localparam logic [3:0] OP_WR32  = 4'd6;
  localparam logic [3:0] OP_RDB   = 4'd7;
  localparam logic [3:0] OP_WRB   = 4'd8;
  localparam logic [3:0] OP_RDW   = 4'd9;
  localparam logic [3:0] OP_WRW   = 4'd10;

  localparam logic [3:0] CMD_RESET = 4'b0000;
  localparam logic [3:0] CMD_WRITE = 4'b0010;
  localparam logic [3:0] CMD_READ  = 4'b0011;

  localparam int HDR_BITS = 16;

  typedef enum logic [2:0] {
    S_IDLE, S_LO, S_HI, S_FETCH, S_TAIL, S_GAP
  } seq_state_e;
endpackage

// File: rtl/spi_sck_div.sv
module spi_sck_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;
  logic             last;

  assign lim  = (half == '0) ? DIV_W'(1) : half;
  assign last = (cnt >= lim - DIV_W'(1));
  assign tick = !clear && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (last)  cnt <= '0;
    else            cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_hdr,
  input  logic [15:0] hdr,
  input  logic        load_byte,
  input  logic [7:0]  byte_in,
  input  logic        shift_tx,
  input  logic        sample_rx,
  input  logic        miso,
  output logic        mosi_bit,
  output logic [7:0]  rx_byte
);
  logic [15:0] tx_sh;
  logic [7:0]  rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
    end else if (load_hdr) begin
      tx_sh <= hdr;
    end else if (load_byte) begin
      tx_sh <= {byte_in, 8'h00};
    end else if (shift_tx) begin
      tx_sh <= {tx_sh[14:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rx_sh <= '0;
    else if (sample_rx) rx_sh <= {rx_sh[6:0], miso};
  end

  assign mosi_bit = tx_sh[15];
  assign rx_byte  = rx_sh;
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_seq_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_div,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [3:0]       req_op,
  input  logic [11:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             spi_sck,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam int CNT_W = LEN_W + 4;

  seq_state_e       state;
  logic [CNT_W-1:0] bit_cnt, total, bit_nxt;
  logic             is_rd, gap_half, done_q, err_q, rdv_q;
  logic [7:0]       rdd_q;

  // request decode
  logic [LEN_W-1:0] nb;
  logic [3:0]       cmd;
  logic             legal, need_al, rd_op, bad;
  logic [15:0]      hdr;

  always_comb begin
    nb      = '0;
    cmd     = CMD_RESET;
    legal   = 1'b1;
    need_al = 1'b0;
    rd_op   = 1'b0;
    case (req_op)
      OP_RESET: ;
      OP_RD8:  begin nb = LEN_W'(1); cmd = CMD_READ;  rd_op = 1'b1; end
      OP_WR8:  begin nb = LEN_W'(1); cmd = CMD_WRITE; end
      OP_RD16: begin nb = LEN_W'(2); cmd = CMD_READ;  rd_op = 1'b1; end
      OP_WR16: begin nb = LEN_W'(2); cmd = CMD_WRITE; end
      OP_RD32: begin nb = LEN_W'(4); cmd = CMD_READ;  rd_op = 1'b1; need_al = 1'b1; end
      OP_WR32: begin nb = LEN_W'(4); cmd = CMD_WRITE; need_al = 1'b1; end
      OP_RDB:  begin nb = req_len;   cmd = CMD_READ;  rd_op = 1'b1; end
      OP_WRB:  begin nb = req_len;   cmd = CMD_WRITE; end
      OP_RDW:  begin nb = req_len;   cmd = CMD_READ;  rd_op = 1'b1; need_al = 1'b1; end
      OP_WRW:  begin nb = req_len;   cmd = CMD_WRITE; need_al = 1'b1; end
      default: legal = 1'b0;
    endcase
    bad = !legal || (need_al && (req_addr[1:0] != 2'b00));
    hdr = (req_op == OP_RESET) ? 16'h0000 : {cmd, req_addr};
  end

  logic tick, accept, load_hdr;
  logic [7:0] rx_byte;
  logic mosi_bit;

  assign accept   = req_valid && (state == S_IDLE);
  assign load_hdr = accept && !bad;
  assign bit_nxt  = bit_cnt + CNT_W'(1);

  spi_sck_div #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clear ((state == S_IDLE) || (state == S_FETCH)),
    .half  (half_div),
    .tick  (tick)
  );

  spi_shift_unit u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_hdr  (load_hdr),
    .hdr       (hdr),
    .load_byte ((state == S_FETCH) && wr_valid),
    .byte_in   (wr_data),
    .shift_tx  ((state == S_HI) && tick),
    .sample_rx ((state == S_LO) && tick),
    .miso      (spi_miso),
    .mosi_bit  (mosi_bit),
    .rx_byte   (rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      bit_cnt  <= '0;
      total    <= '0;
      is_rd    <= 1'b0;
      gap_half <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      rdv_q    <= 1'b0;
      rdd_q    <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      rdv_q  <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          if (bad) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else begin
            state   <= S_LO;
            is_rd   <= rd_op;
            bit_cnt <= '0;
            total   <= CNT_W'({nb, 3'b000}) + CNT_W'(HDR_BITS);
          end
        end
        S_LO: if (tick) state <= S_HI;
        S_HI: if (tick) begin
          bit_cnt <= bit_nxt;
          if (is_rd && (bit_nxt > CNT_W'(HDR_BITS)) && (bit_nxt[2:0] == 3'b000)) begin
            rdv_q <= 1'b1;
            rdd_q <= rx_byte;
          end
          if (bit_nxt == total)
            state <= S_TAIL;
          else if (!is_rd && (bit_nxt >= CNT_W'(HDR_BITS)) && (bit_nxt[2:0] == 3'b000))
            state <= S_FETCH;
          else
            state <= S_LO;
        end
        S_FETCH: if (wr_valid) state <= S_LO;
        S_TAIL: if (tick) begin
          state    <= S_GAP;
          gap_half <= 1'b0;
        end
        S_GAP: if (tick) begin
          if (gap_half) begin
            state  <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            gap_half <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign busy      = (state != S_IDLE);
  assign wr_ready  = (state == S_FETCH);
  assign spi_sck   = (state == S_HI);
  assign spi_cs_n  = (state == S_IDLE) || (state == S_GAP);
  assign spi_mosi  = spi_cs_n ? 1'b0 : mosi_bit;
  assign done      = done_q;
  assign err       = err_q;
  assign rd_valid  = rdv_q;
  assign rd_data   = rdd_q;
endmodule

// File: rtl/spi_cmd_seq_chk.sv
module spi_cmd_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic err,
  input logic wr_ready,
  input logic rd_valid,
  input logic spi_sck,
  input logic spi_cs_n,
  input logic spi_mosi
);
  assert_sck_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  assert_err_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && spi_cs_n));

  assert_wr_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (!spi_cs_n && !spi_sck));

  assert_cs_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> spi_cs_n);

  assert_rd_framed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);
endmodule

bind spi_cmd_seq spi_cmd_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .wr_ready (wr_ready),
  .rd_valid (rd_valid),
  .spi_sck  (spi_sck),
  .spi_cs_n (spi_cs_n),
  .spi_mosi (spi_mosi)
);

// File: tb/spi_cmd_seq_test.sv
module spi_cmd_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] half_div = 8'd2;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [3:0] req_op = '0;
  logic [11:0] req_addr = '0;
  logic [7:0] req_len = '0;
  logic [7:0] wr_data = '0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic       busy, done, err;
  logic       spi_sck, spi_cs_n, spi_mosi;
  logic       spi_miso = 1'b0;

  always #10 clk = ~clk;

  spi_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .half_div(half_div),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_len(req_len),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid),
    .busy(busy), .done(done), .err(err),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [7:0] resp(input int k);
    return 8'(k * 37) ^ 8'h5A;
  endfunction

  // behavioural slave: samples MOSI on rising SCK, drives MISO on falling SCK
  int          sl_n = 0;
  logic [15:0] sl_hdr = '0;
  logic [7:0]  sl_sh = '0;
  logic [7:0]  sl_data [0:63];
  int          frames = 0;
  int          fr_bits = 0;

  always @(negedge spi_cs_n or posedge spi_sck) begin
    if (!spi_sck) begin
      sl_n = 0;
    end else begin
      if (sl_n < 16) sl_hdr = {sl_hdr[14:0], spi_mosi};
      else begin
        sl_sh = {sl_sh[6:0], spi_mosi};
        if (((sl_n - 16) % 8) == 7) sl_data[(sl_n - 16) / 8] = sl_sh;
      end
      sl_n++;
    end
  end

  always @(negedge spi_sck) begin
    if (!spi_cs_n && sl_n >= 16) begin
      logic [7:0] rb;
      rb = resp((sl_n - 16) / 8);
      spi_miso = rb[7 - ((sl_n - 16) % 8)];
    end
  end

  always @(posedge spi_cs_n) begin
    frames++;
    fr_bits = sl_n;
  end

  // line monitors
  int   exp_half = 2;
  int   hi_run = 0, hi_bad = 0, mosi_bad = 0;
  int   gap_run = 0, last_gap = 0, cs_low_n = 0;
  logic prev_sck = 1'b0, prev_mosi = 1'b0;

  always @(negedge clk) begin
    if (spi_sck) hi_run++;
    else begin
      if (hi_run != 0 && hi_run != exp_half) hi_bad++;
      hi_run = 0;
    end
    if (spi_sck && prev_sck && spi_mosi != prev_mosi) mosi_bad++;
    prev_sck = spi_sck;
    prev_mosi = spi_mosi;
    if (spi_cs_n) gap_run++;
    else begin
      if (gap_run != 0) last_gap = gap_run;
      gap_run = 0;
      cs_low_n++;
    end
  end

  logic hs = 1'b0;
  always @(posedge clk) hs <= wr_valid && wr_ready;

  logic [7:0] wr_src [0:63];
  logic [7:0] rd_buf [0:63];
  int wi, rd_n;
  bit got_done, got_err, busy_after;

  task automatic run_xfer(input logic [3:0] op, input logic [11:0] addr,
                          input logic [7:0] len, input int n_wr, input int stall);
    int guard;
    int wait_c;
    wi = 0; rd_n = 0; got_done = 0; got_err = 0; wait_c = stall; guard = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = op; req_addr = addr; req_len = len; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    busy_after = busy;
    while (!got_done && guard < 20000) begin
      if (hs) begin wi++; wait_c = stall; end
      if (rd_valid) begin rd_buf[rd_n] = rd_data; rd_n++; end
      if (done) begin got_done = 1; got_err = err; end
      if (!got_done) begin
        if (wi < n_wr) begin
          if (wait_c > 0) begin wr_valid = 1'b0; wait_c--; end
          else begin wr_valid = 1'b1; wr_data = wr_src[wi]; end
        end else wr_valid = 1'b0;
        @(negedge clk);
        guard++;
      end
    end
    wr_valid = 1'b0;
    chk(got_done, "R6 done timeout", guard, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(spi_cs_n === 1'b1, "R1 cs_n", spi_cs_n, 1);
    chk(spi_sck === 1'b0, "R1 sck", spi_sck, 0);
    chk({busy, done, err, rd_valid, wr_ready} === 5'b0, "R1 status",
        {busy, done, err, rd_valid, wr_ready}, 0);
    chk(req_ready === 1'b1, "R1 req_ready", req_ready, 1);
  endtask

  task automatic t_reset_op;
    int f0 = frames;
    run_xfer(4'd0, 12'hABC, 8'd5, 0, 0);
    chk(frames - f0 == 1, "R4 reset one frame", frames - f0, 1);
    chk(sl_hdr == 16'h0000, "R2 reset header", sl_hdr, 16'h0000);
    chk(fr_bits == 16, "R2 reset no data", fr_bits, 16);
    chk(!got_err, "R6 no err", got_err, 0);
  endtask

  task automatic t_wr_byte;
    wr_src[0] = 8'hA5;
    run_xfer(4'd2, 12'h123, 8'd0, 1, 0);
    chk(busy_after, "R6 busy after accept", busy_after, 1);
    chk(sl_hdr == {4'b0010, 12'h123}, "R2 write header", sl_hdr, {4'b0010, 12'h123});
    chk(fr_bits == 24, "R4 write byte bits", fr_bits, 24);
    chk(sl_data[0] == 8'hA5, "R7 write byte data", sl_data[0], 8'hA5);
  endtask

  task automatic t_rd(input logic [3:0] op, input logic [11:0] addr,
                      input logic [7:0] len, input int nb, input string rq);
    run_xfer(op, addr, len, 0, 0);
    chk(sl_hdr == {4'b0011, addr}, {rq, " read header R2"}, sl_hdr, {4'b0011, addr});
    chk(fr_bits == 16 + 8 * nb, {rq, " bits R4"}, fr_bits, 16 + 8 * nb);
    chk(rd_n == nb, {rq, " byte count R9"}, rd_n, nb);
    for (int k = 0; k < nb; k++)
      chk(rd_buf[k] == resp(k), {rq, " data R9"}, rd_buf[k], resp(k));
  endtask

  task automatic t_refuse(input logic [3:0] op, input logic [11:0] addr, input string rq);
    int f0 = frames;
    int c0 = cs_low_n;
    run_xfer(op, addr, 8'd4, 4, 0);
    chk(got_err, {rq, " err R5"}, got_err, 1);
    chk(frames == f0, {rq, " no frame R5"}, frames - f0, 0);
    repeat (4) @(negedge clk);
    chk(cs_low_n == c0, {rq, " cs idle R5"}, cs_low_n - c0, 0);
  endtask

  task automatic t_wr_array;
    int b0 = hi_bad;
    for (int k = 0; k < 5; k++) wr_src[k] = 8'(8'h30 + k * 7);
    run_xfer(4'd8, 12'h010, 8'd5, 5, 7);
    chk(sl_hdr == {4'b0010, 12'h010}, "R10 array header", sl_hdr, {4'b0010, 12'h010});
    chk(fr_bits == 56, "R10 array bits", fr_bits, 56);
    chk(wi == 5, "R7 handshakes", wi, 5);
    for (int k = 0; k < 5; k++)
      chk(sl_data[k] == wr_src[k], "R7 stalled data", sl_data[k], wr_src[k]);
    chk(hi_bad == b0, "R7 sck held during stall", hi_bad - b0, 0);
  endtask

  task automatic t_zero_len;
    run_xfer(4'd10, 12'h020, 8'd0, 2, 0);
    chk(fr_bits == 16, "R10 zero length header only", fr_bits, 16);
    chk(wi == 0, "R10 zero length no write taken", wi, 0);
  endtask

  task automatic t_div(input logic [7:0] h, input int eh);
    int b0 = hi_bad;
    int m0 = mosi_bad;
    half_div = h;
    exp_half = eh;
    t_rd(4'd5, 12'h008, 8'd0, 4, "R3 divider");
    chk(hi_bad == b0, "R3 sck high length", hi_bad - b0, 0);
    chk(mosi_bad == m0, "R3 mosi stable high", mosi_bad - m0, 0);
  endtask

  task automatic t_gap;
    half_div = 8'd3;
    exp_half = 3;
    wr_src[0] = 8'h11;
    run_xfer(4'd2, 12'h001, 8'd0, 1, 0);
    run_xfer(4'd2, 12'h002, 8'd0, 1, 0);
    chk(last_gap >= 6, "R8 cs gap", last_gap, 6);
    half_div = 8'd2;
    exp_half = 2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_reset_op();
    t_wr_byte();
    t_rd(4'd5, 12'h404, 8'd0, 4, "R9 word");
    t_rd(4'd3, 12'h0FE, 8'd0, 2, "R4 half");
    t_rd(4'd1, 12'h3FF, 8'd0, 1, "R4 byte");
    t_rd(4'd9, 12'h200, 8'd8, 8, "R10 word array");
    t_refuse(4'd6, 12'h102, "R5 misaligned write word");
    t_refuse(4'd9, 12'h001, "R5 misaligned read array");
    t_refuse(4'hE, 12'h000, "R5 unknown op");
    t_wr_array();
    t_zero_len();
    t_div(8'd1, 1);
    t_div(8'd3, 3);
    t_div(8'd0, 1);
    t_gap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule